// File: doc/BRIEF.md
# Priority DMA Channel Arbiter

This block sits between eight DMA channels and one shared transfer engine. On each decision it looks at which channels are ready and picks one. It grants that channel for a single item transfer, which is one read followed by one write. It then waits for the engine's done pulse and decides again. Channels driven by a peripheral use a four-phase request/acknowledge handshake. Channels in memory-to-memory mode are started by software and need no request.

Each channel presents four things:

- a two-bit priority level;
- an enable bit;
- a flag saying its item count is nonzero;
- a flag saying a transfer error is pending.

A memory-to-memory channel is always ready while it is eligible. After one of its items, it steps aside for any other ready channel, even one of lower priority. This keeps a long software-driven copy from starving the peripherals.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, no grant is outstanding and every acknowledge output is low.
- R2: The priority field decodes as 2'b00 low, 2'b01 medium, 2'b10 high and 2'b11 very high. Among ready channels, one at a higher level always wins.
- R3: When ready channels share the top level, the one with the lowest index wins.
- R4: A channel is ready only while three things hold: its enable is set, its count-nonzero flag is set and its error flag is clear. A request from a channel that is not ready is ignored: it gets no grant and no acknowledge.
- R5: A peripheral channel's acknowledge rises on the same clock edge as its grant. A memory-to-memory channel never drives its acknowledge.
- R6: Once high, an acknowledge stays high for as long as the request is high. It falls on the first clock edge that samples the request low.
- R7: While a channel's acknowledge is high, its request is not taken again, even after its transfer has finished.
- R8: Only one grant is outstanding at a time. It holds a fixed channel index until the engine's done pulse. The next grant comes no earlier than the edge after the one that sampled done.
- R9: A memory-to-memory channel is ready continuously. After one of its items, any other ready channel is served first, whatever its level. With no other channel ready, the same memory-to-memory channel is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_en_i | input | NCH | Channel enable |
| ch_cnt_nz_i | input | NCH | Remaining item count is nonzero |
| ch_err_i | input | NCH | Transfer error pending on the channel |
| ch_m2m_i | input | NCH | Channel runs memory-to-memory, software triggered |
| ch_prio_i | input | NCH*2 | Priority level, two bits per channel, channel i at [2i+1:2i] |
| req_i | input | NCH | Peripheral request per channel |
| ack_o | output | NCH | Peripheral acknowledge per channel |
| done_i | input | 1 | Engine pulse: the granted single transfer has finished |
| gnt_valid_o | output | 1 | A grant is outstanding |
| gnt_id_o | output | $clog2(NCH) | Index of the granted channel |

## Verification
The bench targets four corner cases:

- **Stuck acknowledge with a late request drop.** A peripheral keeps its request high long after its item completes. A design that re-arms on request level would issue a second grant. A design that drops the acknowledge early would break the handshake.
- **Ineligibility on its own.** Enable, count and error are each made false one at a time while a request is held. A design that forgets any one of them would grant the channel.
- **Software copy against a low-priority peripheral.** A very-high memory-to-memory channel competes with a low-priority peripheral. A design without the yield rule would starve the peripheral.
- **Held grant under a slow engine.** The engine is slowed down to check that the grant is held until done. An arbiter that decides while busy would change the granted index in mid-transfer.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W = 2;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_LOW   = 2'b00,
    PRIO_MED   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_VHIGH = 2'b11
  } prio_e;

  function automatic logic prio_above(input prio_e a, input prio_e b);
    return a > b;
  endfunction
endpackage

// File: rtl/dma_arb_hs.sv
module dma_arb_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic elig_i,
  input  logic m2m_i,
  input  logic take_i,
  output logic ack_o,
  output logic want_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
    end else if (take_i && !m2m_i) begin
      ack_q <= 1'b1;
    end else if (ack_q && !req_i) begin
      ack_q <= 1'b0;
    end
  end

  // software-triggered channels are always asking while eligible
  assign want_o = elig_i && (m2m_i || (req_i && !ack_q));
  assign ack_o  = ack_q;

  a_r6_ack_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && req_i) |=> ack_q)
    else $error("ack dropped while request high");

  a_r5_ack_from_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(take_i && !m2m_i))
    else $error("ack rose without a peripheral grant");

  a_r4_take_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> elig_i)
    else $error("grant to ineligible channel");
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]        cand_i,
  input  logic [NCH*PRIO_W-1:0] prio_i,
  output logic                  valid_o,
  output logic [IW-1:0]         idx_o
);
  logic          found;
  logic [IW-1:0] idx;
  prio_e         best;

  // strict compare keeps the lowest index among equal levels
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = PRIO_LOW;
    for (int i = 0; i < NCH; i++) begin
      if (cand_i[i] && (!found || prio_above(prio_e'(prio_i[i*PRIO_W +: PRIO_W]), best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio_e'(prio_i[i*PRIO_W +: PRIO_W]);
      end
    end
  end

  assign valid_o = found;
  assign idx_o   = idx;

  always_comb begin
    a_r2_pick_is_candidate: assert (!found || cand_i[idx])
      else $error("picked channel is not a candidate");
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        ch_en_i,
  input  logic [NCH-1:0]        ch_cnt_nz_i,
  input  logic [NCH-1:0]        ch_err_i,
  input  logic [NCH-1:0]        ch_m2m_i,
  input  logic [NCH*PRIO_W-1:0] ch_prio_i,
  input  logic [NCH-1:0]        req_i,
  output logic [NCH-1:0]        ack_o,
  input  logic                  done_i,
  output logic                  gnt_valid_o,
  output logic [IW-1:0]         gnt_id_o
);
  logic [NCH-1:0] elig, want, take, last_oh, others, cand;
  logic           pick_valid, issue;
  logic [IW-1:0]  pick_idx;
  logic           busy_q, last_vld_q;
  logic [IW-1:0]  gnt_id_q, last_id_q;

  assign elig = ch_en_i & ch_cnt_nz_i & ~ch_err_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign take[g]    = issue && (pick_idx == IW'(g));
    assign last_oh[g] = last_vld_q && (last_id_q == IW'(g));

    dma_arb_hs u_hs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[g]),
      .elig_i (elig[g]),
      .m2m_i  (ch_m2m_i[g]),
      .take_i (take[g]),
      .ack_o  (ack_o[g]),
      .want_o (want[g])
    );
  end

  // a software copy steps aside whenever anyone else is waiting
  assign others = want & ~last_oh;
  assign cand   = (last_vld_q && |others) ? others : want;

  dma_arb_pick #(.NCH(NCH)) u_pick (
    .cand_i  (cand),
    .prio_i  (ch_prio_i),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign issue = !busy_q && pick_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      gnt_id_q   <= '0;
      last_vld_q <= 1'b0;
      last_id_q  <= '0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (pick_valid) begin
      busy_q     <= 1'b1;
      gnt_id_q   <= pick_idx;
      last_vld_q <= ch_m2m_i[pick_idx];
      last_id_q  <= pick_idx;
    end
  end

  assign gnt_valid_o = busy_q;
  assign gnt_id_o    = gnt_id_q;

  a_r8_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> (busy_q && $stable(gnt_id_q)))
    else $error("grant changed before done");

  a_r8_gap_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> !busy_q)
    else $error("grant not released after done");

  a_r9_m2m_yields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && last_vld_q && |(want & ~last_oh)) |-> (pick_idx != last_id_q))
    else $error("memory copy did not yield");
endmodule

// File: tb/sim_dma_prio_arbiter.sv
`timescale 1ns/1ps
module sim_dma_prio_arbiter;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] en = '1, nz = '1, err = '0, m2m = '0, req = '0, ack;
  logic [2*N-1:0] prio = '0;
  logic done = 1'b0, gnt_valid;
  logic [2:0] gnt_id;

  int errors = 0, checks = 0, cyc = 0, lat = 2, lat_cnt = 0;
  bit auto_drop [N];
  bit prev_valid = 0, ack0_seen = 0;
  int gseq [$];

  int  m_busy, m_id, m_last;
  bit  m_ack [N];

  always #2.5 clk = ~clk;

  dma_prio_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .ch_en_i(en), .ch_cnt_nz_i(nz), .ch_err_i(err),
    .ch_m2m_i(m2m), .ch_prio_i(prio), .req_i(req), .ack_o(ack), .done_i(done),
    .gnt_valid_o(gnt_valid), .gnt_id_o(gnt_id)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference model, behavioural
  always @(posedge clk) begin : model
    bit wantv [N];
    bit nack [N];
    bit others;
    int best, bp, p;
    if (!rst_n) begin
      m_busy = 0; m_id = 0; m_last = -1;
      for (int i = 0; i < N; i++) m_ack[i] = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        wantv[i] = en[i] && nz[i] && !err[i] && (m2m[i] || (req[i] && !m_ack[i]));
        nack[i]  = (m_ack[i] && !req[i]) ? 1'b0 : m_ack[i];
      end
      if (m_busy != 0) begin
        if (done) m_busy = 0;
      end else begin
        others = 0;
        if (m_last >= 0)
          for (int i = 0; i < N; i++) if (i != m_last && wantv[i]) others = 1;
        if (others) wantv[m_last] = 0;
        best = -1; bp = -1;
        for (int i = 0; i < N; i++) begin
          p = int'(prio[i*2 +: 2]);
          if (wantv[i] && p > bp) begin best = i; bp = p; end
        end
        if (best >= 0) begin
          m_busy = 1; m_id = best;
          if (!m2m[best]) nack[best] = 1;
          m_last = m2m[best] ? best : -1;
        end
      end
      for (int i = 0; i < N; i++) m_ack[i] = nack[i];
    end
  end

  // compare, monitor, engine and peripheral responders
  always @(negedge clk) begin
    if (rst_n) begin
      chk(gnt_valid == (m_busy != 0), "R8 grant valid", int'(gnt_valid), m_busy);
      if (m_busy != 0) chk(int'(gnt_id) == m_id, "R8 grant id", int'(gnt_id), m_id);
      for (int i = 0; i < N; i++)
        chk(ack[i] == m_ack[i], "R6 ack vs model", int'(ack[i]), int'(m_ack[i]));
      if (gnt_valid && !prev_valid) gseq.push_back(int'(gnt_id));
      prev_valid = gnt_valid;
      if (ack[0]) ack0_seen = 1;
      for (int i = 0; i < N; i++) if (auto_drop[i] && ack[i]) req[i] = 1'b0;
      if (done) done = 1'b0;
      else if (gnt_valid) begin
        lat_cnt++;
        if (lat_cnt >= lat) begin done = 1'b1; lat_cnt = 0; end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    int n;
    for (int i = 0; i < N; i++) auto_drop[i] = 1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(gnt_valid == 0, "R1 no grant after reset", int'(gnt_valid), 0);
    chk(ack == '0, "R1 acks low after reset", int'(ack), 0);

    // R2: very high beats medium
    prio[2*2 +: 2] = 2'b01; prio[5*2 +: 2] = 2'b11;
    req[2] = 1; req[5] = 1;
    tick();
    chk(gnt_id == 3'd5, "R2 higher level first", int'(gnt_id), 5);
    chk(ack[5] == 1, "R5 ack with grant", int'(ack[5]), 1);
    while (gseq.size() < 2) tick();
    chk(gseq[0] == 5, "R2 order first", gseq[0], 5);
    chk(gseq[1] == 2, "R2 order second", gseq[1], 2);
    repeat (6) tick(); gseq.delete();

    // R3: equal level, lowest index
    prio[1*2 +: 2] = 2'b10; prio[6*2 +: 2] = 2'b10;
    req[6] = 1; req[1] = 1;
    while (gseq.size() < 2) tick();
    chk(gseq[0] == 1, "R3 lowest index wins", gseq[0], 1);
    repeat (6) tick(); gseq.delete();

    // R4: each ineligibility cause on its own
    en[3] = 0; req[3] = 1;
    repeat (10) tick();
    chk(gseq.size() == 0 && ack[3] == 0, "R4 disabled ignored", gseq.size(), 0);
    en[3] = 1; nz[3] = 0;
    repeat (10) tick();
    chk(gseq.size() == 0 && ack[3] == 0, "R4 zero count ignored", gseq.size(), 0);
    nz[3] = 1; err[3] = 1;
    repeat (10) tick();
    chk(gseq.size() == 0 && ack[3] == 0, "R4 error ignored", gseq.size(), 0);
    err[3] = 0;
    repeat (10) tick();
    chk(gseq.size() == 1 && gseq[0] == 3, "R4 eligible served", gseq.size(), 1);
    repeat (4) tick(); gseq.delete();

    // R7 / R6: request held after item done
    auto_drop[4] = 0; req[4] = 1;
    repeat (20) tick();
    chk(gseq.size() == 1, "R7 no regrant while ack high", gseq.size(), 1);
    chk(ack[4] == 1, "R6 ack held with request", int'(ack[4]), 1);
    req[4] = 0;
    tick();
    chk(ack[4] == 0, "R6 ack falls after request", int'(ack[4]), 0);
    auto_drop[4] = 1;
    repeat (4) tick(); gseq.delete();

    // R8: grant held for the engine latency
    lat = 6; req[0] = 1;
    while (!gnt_valid) tick();
    n = 0;
    while (gnt_valid) begin
      chk(gnt_id == 3'd0, "R8 id stable", int'(gnt_id), 0);
      n++; tick();
    end
    chk(n == 6, "R8 held until done", n, 6);
    lat = 2;
    repeat (4) tick(); gseq.delete();

    // R9: software copy yields to a low-priority peripheral
    ack0_seen = 0;
    prio[0*2 +: 2] = 2'b11; prio[7*2 +: 2] = 2'b00;
    m2m[0] = 1; req[7] = 1;
    repeat (40) tick();
    en[0] = 0;
    repeat (6) tick();
    chk(gseq.size() >= 5, "R9 copy runs back to back", gseq.size(), 5);
    chk(gseq[0] == 0, "R9 copy first", gseq[0], 0);
    chk(gseq[1] == 7, "R9 yields to lower level", gseq[1], 7);
    chk(gseq[2] == 0, "R9 copy resumes", gseq[2], 0);
    chk(ack0_seen == 0, "R5 no ack for copy channel", int'(ack0_seen), 0);
    m2m[0] = 0; en[0] = 1;
    repeat (4) tick();

    finish_run();
  end
endmodule